// File: doc/BRIEF.md
# Fuse-Map Access Controller with Security Lock

This controller sits between a test port and two stores: a byte-wide configuration fuse array and a 64-bit user signature held as eight bytes. Each cycle the test port may present one request: program a fuse byte, read a fuse byte back, preload the output registers, write or read a signature byte, set the security lock, or erase everything. The controller answers every request on the following cycle. The answer is a one-cycle grant or a one-cycle deny pulse, together with the read data.

The security lock is a single bit that protects the fuse pattern against copying. Once it is set, fuse read-back and register preload are refused, and the refusal starts with the very next request, with no reset in between. This is why locking has to be the final programming step. Signature reads stay open whatever the lock state. Only a full erase clears the lock, and the erase also wipes the fuse array and the signature.

Top module: `fuse_guard`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, grant, deny, rd_data and preload_q are all zero. The lock is clear, and all fuse and signature bytes read as zero.
- R2: A request presented with req_valid high is answered in the next cycle by exactly one of grant or deny, high for that cycle only. A cycle with req_valid low produces neither. Opcode 0 is a no-op that is granted with zero data.
- R3: Opcode 1 writes req_wdata into fuse byte req_addr and is granted. When the lock is clear, opcode 2 is granted and returns that fuse byte on rd_data.
- R4: Opcode 6 sets the lock and is granted. Any opcode 2 request presented in the cycle right after it, or later, is denied. A denied request returns rd_data of zero.
- R5: Opcode 3 loads req_wdata[NREG-1:0] into preload_q, one bit per output register, 1 meaning high. This happens only while the lock is clear. While the lock is set, opcode 3 is denied and preload_q keeps its value.
- R6: Opcode 4 writes req_wdata into signature byte req_addr[2:0], and opcode 5 returns that byte. Byte 0 is the least significant byte of the 64-bit signature. Both opcodes are granted whether or not the lock is set.
- R7: Opcode 7 is granted and clears the lock, every fuse byte and the whole signature. After it, fuse read-back and preload are granted again.
- R8: While the lock is set, fuse programming (opcode 1) is still granted. The lock stays set across any number of requests until an erase.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Request opcode (0 to 7) |
| req_addr | input | AW | Fuse byte address; the low 3 bits select the signature byte |
| req_wdata | input | 8 | Write data or preload pattern |
| grant | output | 1 | Previous request accepted |
| deny | output | 1 | Previous request refused |
| rd_data | output | 8 | Read data for the previous request; zero when it was denied |
| preload_q | output | NREG | Output register state |

## Verification
Two things meet on a single clock edge: the lock write taking hold, and the access check for the request that follows it. The bench provokes this by issuing a lock request and then a fuse read-back on the very next cycle with no idle gap, and again with a preload. It judges the result by requiring deny rather than grant for that second request, zero read data, and preload_q unchanged. In the same locked window a signature read and a fuse program must still be granted.

// File: rtl/fuse_guard.sv
`timescale 1ns/1ps
module fuse_guard #(
  parameter int FUSE_BYTES = 32,
  parameter int NREG = 8,
  localparam int AW = $clog2(FUSE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [7:0]      req_wdata,
  output logic            grant,
  output logic            deny,
  output logic [7:0]      rd_data,
  output logic [NREG-1:0] preload_q
);
  localparam logic [2:0] OP_NOP = 3'd0, OP_PROG = 3'd1, OP_VERIFY = 3'd2,
                         OP_PRELOAD = 3'd3, OP_SIGWR = 3'd4, OP_SIGRD = 3'd5,
                         OP_LOCK = 3'd6, OP_ERASE = 3'd7;

  logic [7:0]  fuse_q [FUSE_BYTES];
  logic [63:0] sig_q;
  logic        lock_q;
  logic [7:0]  rd_next;

  wire guarded = (req_op == OP_VERIFY) || (req_op == OP_PRELOAD);
  wire refuse  = req_valid && lock_q && guarded;
  wire accept  = req_valid && !refuse;
  wire [2:0] sig_sel = req_addr[2:0];

  always_comb begin
    rd_next = '0;
    if (accept) begin
      case (req_op)
        OP_VERIFY: rd_next = fuse_q[req_addr];
        OP_SIGRD:  rd_next = sig_q[sig_sel*8 +: 8];
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= 1'b0;
      deny      <= 1'b0;
      rd_data   <= '0;
      preload_q <= '0;
      lock_q    <= 1'b0;
      sig_q     <= '0;
      for (int i = 0; i < FUSE_BYTES; i++) fuse_q[i] <= '0;
    end else begin
      grant   <= accept;
      deny    <= refuse;
      rd_data <= rd_next;
      if (accept) begin
        case (req_op)
          OP_PROG:    fuse_q[req_addr] <= req_wdata;
          OP_PRELOAD: preload_q <= req_wdata[NREG-1:0];
          OP_SIGWR:   sig_q[sig_sel*8 +: 8] <= req_wdata;
          OP_LOCK:    lock_q <= 1'b1;
          OP_ERASE: begin
            lock_q <= 1'b0;
            sig_q  <= '0;
            for (int i = 0; i < FUSE_BYTES; i++) fuse_q[i] <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module fuse_guard_chk #(
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [2:0]      req_op,
  input logic            grant,
  input logic            deny,
  input logic [7:0]      rd_data,
  input logic [NREG-1:0] preload_q,
  input logic            lock_q
);
  a_r2_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant ^ deny));
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !deny));
  a_r4_locked_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && lock_q) |=> (deny && rd_data == 8'd0));
  a_r4_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> (rd_data == 8'd0));
  a_r5_locked_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && lock_q) |=> (deny && $stable(preload_q)));
  a_r6_sig_open: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 3'd4 || req_op == 3'd5)) |=> grant);
  a_r7_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd7) |=> (grant && !lock_q));
  a_r8_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(req_valid && req_op == 3'd7)) |=> lock_q);
endmodule

bind fuse_guard fuse_guard_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .grant(grant), .deny(deny), .rd_data(rd_data), .preload_q(preload_q),
  .lock_q(lock_q)
);

// File: tb/tb_fuse_guard.sv
`timescale 1ns/1ps
module tb_fuse_guard;
  localparam int FUSE_BYTES = 32;
  localparam int NREG = 8;
  localparam int AW = $clog2(FUSE_BYTES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic grant, deny;
  logic [7:0] rd_data;
  logic [NREG-1:0] preload_q;

  int total = 0;
  int bad = 0;
  logic g_s, d_s;
  logic [7:0] r_s;

  always #4 clk = ~clk;

  fuse_guard #(.FUSE_BYTES(FUSE_BYTES), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant), .deny(deny),
    .rd_data(rd_data), .preload_q(preload_q));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    g_s = grant; d_s = deny; r_s = rd_data;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 grant", {31'd0, grant}, 0);
    check("R1 deny", {31'd0, deny}, 0);
    check("R1 rd_data", {24'd0, rd_data}, 0);
    check("R1 preload_q", {24'd0, preload_q}, 0);
    issue(3'd2, 5'd9, 8'h00);
    check("R1 fuse blank", {24'd0, r_s}, 0);
    check("R1 unlocked", {31'd0, g_s}, 1);
    issue(3'd5, 5'd3, 8'h00);
    check("R1 sig blank", {24'd0, r_s}, 0);
  endtask

  task automatic t_idle_nop();
    idle();
    check("R2 idle grant", {31'd0, grant}, 0);
    check("R2 idle deny", {31'd0, deny}, 0);
    issue(3'd0, 5'd0, 8'hFF);
    check("R2 nop grant", {30'd0, g_s, d_s}, 2);
    check("R2 nop data", {24'd0, r_s}, 0);
    idle();
    check("R2 pulse one cycle", {30'd0, grant, deny}, 0);
  endtask

  task automatic t_prog_verify();
    for (int i = 0; i < 4; i++) begin
      issue(3'd1, 5'(i * 7), 8'(8'h3C ^ (i * 17)));
      check("R3 prog grant", {30'd0, g_s, d_s}, 2);
    end
    for (int i = 3; i >= 0; i--) begin
      issue(3'd2, 5'(i * 7), 8'h00);
      check("R3 verify data", {24'd0, r_s}, {24'd0, 8'(8'h3C ^ (i * 17))});
      check("R3 verify grant", {30'd0, g_s, d_s}, 2);
    end
  endtask

  task automatic t_preload();
    issue(3'd3, 5'd0, 8'hA5);
    check("R5 preload grant", {30'd0, g_s, d_s}, 2);
    check("R5 preload value", {24'd0, preload_q}, 32'hA5);
    issue(3'd3, 5'd0, 8'h5A);
    check("R5 preload value 2", {24'd0, preload_q}, 32'h5A);
  endtask

  task automatic t_signature();
    for (int i = 0; i < 8; i++) issue(3'd4, 5'(i), 8'(8'h10 + i));
    for (int i = 0; i < 8; i++) begin
      issue(3'd5, 5'(i + 8), 8'h00);
      check("R6 sig read low3 bits", {24'd0, r_s}, {24'd0, 8'(8'h10 + i)});
    end
  endtask

  task automatic t_lock();
    issue(3'd6, 5'd0, 8'h00);
    check("R4 lock grant", {30'd0, g_s, d_s}, 2);
    issue(3'd2, 5'd7, 8'h00);
    check("R4 verify denied next", {30'd0, g_s, d_s}, 1);
    check("R4 denied data zero", {24'd0, r_s}, 0);
    issue(3'd3, 5'd0, 8'hFF);
    check("R5 locked preload denied", {30'd0, g_s, d_s}, 1);
    check("R5 locked preload hold", {24'd0, preload_q}, 32'h5A);
    issue(3'd5, 5'd2, 8'h00);
    check("R6 sig locked grant", {30'd0, g_s, d_s}, 2);
    check("R6 sig locked data", {24'd0, r_s}, 32'h12);
    issue(3'd4, 5'd2, 8'hC3);
    check("R6 sig write locked", {30'd0, g_s, d_s}, 2);
    issue(3'd5, 5'd2, 8'h00);
    check("R6 sig rewrite data", {24'd0, r_s}, 32'hC3);
    issue(3'd1, 5'd0, 8'h99);
    check("R8 prog locked grant", {30'd0, g_s, d_s}, 2);
    issue(3'd0, 5'd0, 8'h00);
    issue(3'd2, 5'd0, 8'h00);
    check("R8 lock persists", {30'd0, g_s, d_s}, 1);
    check("R8 denied data zero", {24'd0, r_s}, 0);
  endtask

  task automatic t_erase();
    issue(3'd7, 5'd0, 8'h00);
    check("R7 erase grant", {30'd0, g_s, d_s}, 2);
    issue(3'd2, 5'd0, 8'h00);
    check("R7 verify after erase", {30'd0, g_s, d_s}, 2);
    check("R7 fuse cleared", {24'd0, r_s}, 0);
    issue(3'd2, 5'd7, 8'h00);
    check("R7 fuse cleared 2", {24'd0, r_s}, 0);
    issue(3'd5, 5'd2, 8'h00);
    check("R7 sig cleared", {24'd0, r_s}, 0);
    issue(3'd3, 5'd0, 8'h81);
    check("R7 preload reopened", {24'd0, preload_q}, 32'h81);
  endtask

  initial begin
    #1600000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_nop();
    t_prog_verify();
    t_preload();
    t_signature();
    t_lock();
    t_erase();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset_pre();
    check("R1 in reset grant", {31'd0, grant}, 0);
    check("R1 in reset preload_q", {24'd0, preload_q}, 0);
  endtask
endmodule